// File: doc/BRIEF.md
# Queue-to-Interface Allocation Controller

This block owns a pool of global command queues and lends them to a small set of virtual interfaces, where each borrowed queue appears under a local index. Software configures it through a simple register port: a global enable whose effect is mirrored in a status register after a fixed delay, a read-only word that reports the pool sizes, one allocation record per global queue that names its owning interface and local index, and a configuration/status pair per interface carrying an enable, a 16-bit VM identifier and a hypervisor-owned flag that only privileged writers can set.

From the allocation records the block builds a combinational lookup from an (interface, local index) pair to a global queue number. A page write presented with such a pair is steered to a one-hot strobe on the matching global queue, or dropped when nothing matches. Software enables the block, writes the allocation records, enables each interface and polls the status words until the enables have taken effect.

Top module: `queue_alloc_ctrl`

## Requirements
- R1: After reset every readable register returns zero except the parameter word, and every lookup misses.
- R2: Address 0x4 is read-only and returns log2 of the interface count in bits 11:8, log2 of the global queue count in bits 7:4 and zero elsewhere (0x230 for the default four interfaces and eight queues).
- R3: Bit 0 of address 0x0 is the global enable; bit 0 of address 0x8 shows that enable exactly two clock edges after the edge that stored it.
- R4: The record for global queue q sits at 0x200 + 4*q with bit 0 = allocated, bits 7:1 = local index, bits 20:15 = owning interface; every other bit reads zero.
- R5: The configuration word of interface v sits at 0x1000 + 0x100*v with bit 0 = enable, bits 16:1 = VM identifier and bit 17 = hypervisor-owned; bit 17 stores the written value only when the write is privileged and stores zero otherwise, and a read returns what was stored.
- R6: The status word of interface v (configuration address + 0x4) reports in bit 0 the AND of that interface's enable and the global enable, two clock edges late; bits 3:1 read 1 while the interface enable is set and the global enable is clear, and 0 otherwise, with no delay.
- R7: Clearing the global enable drives every interface status bit 0 to zero two edges later and leaves all allocation records unchanged.
- R8: A lookup of (interface, local index) reports a hit and the lowest-numbered global queue whose record is allocated and matches both fields; with no match it reports a miss.
- R9: A page write raises exactly the strobe bit of the queue the lookup reports; on a miss no strobe bit rises.
- R10: Writes to the read-only words (0x4, 0x8, interface status), to unmapped offsets and to interface or queue indices beyond the pool change no register.
- R11: A record whose interface field is not below the interface count, or whose local index is not below (global queue count / interface count), never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 16 | Register byte address (write and read) |
| regWrData | input | 32 | Register write data |
| regPriv | input | 1 | Write comes from a privileged (hypervisor) agent |
| regRdData | output | 32 | Read data for regAddr, combinational |
| lkIf | input | 6 | Interface number of the page access |
| lkLidx | input | 7 | Local queue index of the page access |
| pgWrEn | input | 1 | Page write request for (lkIf, lkLidx) |
| lookupHit | output | 1 | The pair maps to an allocated global queue |
| lookupQ | output | 3 | Global queue number of the hit |
| qWrStrobe | output | 8 | One-hot write strobe per global queue |

## Verification
The lookup is tried with a unique match, with two records claiming the same pair (telling priority from last-write-wins), after freeing the winning record (showing the runner-up takes over), and with records whose interface or local index lies outside the pool (separating a field compare from a range check). Enable paths are driven in both directions with status reads on each of the following cycles, which separates a two-edge lag from one or three edges and shows the global enable gating interface status. Guest and privileged writes of the same configuration word distinguish the forced hypervisor bit from a stored one, and writes to read-only or unmapped addresses followed by read-back expose decode aliasing.

// File: rtl/qalloc_pkg.sv
package qalloc_pkg;
  // Field widths of the allocation and interface records
  localparam int IF_FLD_W   = 6;
  localparam int LIDX_FLD_W = 7;
  localparam int VMID_W     = 16;
  localparam int IDX_W      = 8;

  // Strobes from the address decoder to the register state
  typedef struct packed {
    logic             wrGlobal;
    logic             wrAlloc;
    logic             wrIfCfg;
    logic             privOk;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/qalloc_regdec.sv
module qalloc_regdec
  import qalloc_pkg::*;
#(
  parameter int IF_LOG2 = 2,
  parameter int Q_LOG2  = 3,
  parameter int ADDR_W  = 16
) (
  input  logic                                  regWrEn,
  input  logic [ADDR_W-1:0]                     regAddr,
  input  logic                                  regPriv,
  input  logic                                  gCfgEn,
  input  logic                                  gStatEn,
  input  logic [(1<<Q_LOG2)-1:0]                allocV,
  input  logic [(1<<Q_LOG2)-1:0][IF_FLD_W-1:0]  allocIf,
  input  logic [(1<<Q_LOG2)-1:0][LIDX_FLD_W-1:0] allocLidx,
  input  logic [(1<<IF_LOG2)-1:0]               ifEn,
  input  logic [(1<<IF_LOG2)-1:0][VMID_W-1:0]   ifVmid,
  input  logic [(1<<IF_LOG2)-1:0]               ifHyp,
  input  logic [(1<<IF_LOG2)-1:0]               ifStatEn,
  output strobe_t                               strb,
  output logic [31:0]                           regRdData
);
  localparam int NIF = 1 << IF_LOG2;
  localparam int NQ  = 1 << Q_LOG2;
  localparam logic [31:0] PARAM_WORD = {20'b0, 4'(IF_LOG2), 4'(Q_LOG2), 4'b0};

  logic isGlobal, isParam, isGStat, inAlloc, inIf, isIfCfg, isIfStat;
  logic [Q_LOG2-1:0]  aIdx;
  logic [IF_LOG2-1:0] vIdx;

  always_comb begin
    isGlobal = (regAddr == '0);
    isParam  = (regAddr == ADDR_W'(4));
    isGStat  = (regAddr == ADDR_W'(8));
    inAlloc  = (int'(regAddr[ADDR_W-1:9]) == 1) && (int'(regAddr[8:2]) < NQ)
               && (regAddr[1:0] == 2'b00);
    inIf     = (int'(regAddr[ADDR_W-1:12]) == 1) && (int'(regAddr[11:8]) < NIF);
    isIfCfg  = inIf && (regAddr[7:0] == 8'h00);
    isIfStat = inIf && (regAddr[7:0] == 8'h04);
    aIdx     = regAddr[Q_LOG2+1:2];
    vIdx     = regAddr[IF_LOG2+7:8];
  end

  always_comb begin
    strb.wrGlobal = regWrEn && isGlobal;
    strb.wrAlloc  = regWrEn && inAlloc;
    strb.wrIfCfg  = regWrEn && isIfCfg;
    strb.privOk   = regPriv;
    strb.idx      = inAlloc ? IDX_W'(regAddr[8:2]) : IDX_W'(regAddr[11:8]);
  end

  always_comb begin
    regRdData = '0;
    if (isGlobal) begin
      regRdData[0] = gCfgEn;
    end else if (isParam) begin
      regRdData = PARAM_WORD;
    end else if (isGStat) begin
      regRdData[0] = gStatEn;
    end else if (inAlloc) begin
      regRdData[0]     = allocV[aIdx];
      regRdData[7:1]   = allocLidx[aIdx];
      regRdData[20:15] = allocIf[aIdx];
    end else if (isIfCfg) begin
      regRdData[0]    = ifEn[vIdx];
      regRdData[16:1] = ifVmid[vIdx];
      regRdData[17]   = ifHyp[vIdx];
    end else if (isIfStat) begin
      regRdData[0]   = ifStatEn[vIdx];
      regRdData[3:1] = (ifEn[vIdx] && !gCfgEn) ? 3'd1 : 3'd0;
    end
  end
endmodule

// File: rtl/qalloc_state.sv
module qalloc_state
  import qalloc_pkg::*;
#(
  parameter int IF_LOG2 = 2,
  parameter int Q_LOG2  = 3
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  strobe_t                                strb,
  input  logic [31:0]                            regWrData,
  input  logic [IF_FLD_W-1:0]                    lkIf,
  input  logic [LIDX_FLD_W-1:0]                  lkLidx,
  input  logic                                   pgWrEn,
  output logic                                   gCfgEn,
  output logic                                   gStatEn,
  output logic [(1<<Q_LOG2)-1:0]                 allocV,
  output logic [(1<<Q_LOG2)-1:0][IF_FLD_W-1:0]   allocIf,
  output logic [(1<<Q_LOG2)-1:0][LIDX_FLD_W-1:0] allocLidx,
  output logic [(1<<IF_LOG2)-1:0]                ifEn,
  output logic [(1<<IF_LOG2)-1:0][VMID_W-1:0]    ifVmid,
  output logic [(1<<IF_LOG2)-1:0]                ifHyp,
  output logic [(1<<IF_LOG2)-1:0]                ifStatEn,
  output logic                                   lookupHit,
  output logic [Q_LOG2-1:0]                      lookupQ,
  output logic [(1<<Q_LOG2)-1:0]                 qWrStrobe
);
  localparam int NIF   = 1 << IF_LOG2;
  localparam int NQ    = 1 << Q_LOG2;
  localparam int LOCAL = NQ / NIF;

  logic                 gLag;
  logic [NIF-1:0]       ifLag;
  logic                 unusedData;

  assign unusedData = ^{regWrData[31:21], regWrData[14:8]};

  // Global enable and its two-stage status mirror
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gCfgEn  <= 1'b0;
      gLag    <= 1'b0;
      gStatEn <= 1'b0;
    end else begin
      gLag    <= gCfgEn;
      gStatEn <= gLag;
      if (strb.wrGlobal) gCfgEn <= regWrData[0];
    end
  end

  // Allocation records
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allocV    <= '0;
      allocIf   <= '0;
      allocLidx <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (strb.wrAlloc && int'(strb.idx) == q) begin
          allocV[q]    <= regWrData[0];
          allocLidx[q] <= regWrData[7:1];
          allocIf[q]   <= regWrData[20:15];
        end
      end
    end
  end

  // Interface configuration and gated status mirror
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifEn     <= '0;
      ifVmid   <= '0;
      ifHyp    <= '0;
      ifLag    <= '0;
      ifStatEn <= '0;
    end else begin
      ifLag    <= ifEn & {NIF{gCfgEn}};
      ifStatEn <= ifLag;
      for (int v = 0; v < NIF; v++) begin
        if (strb.wrIfCfg && int'(strb.idx) == v) begin
          ifEn[v]   <= regWrData[0];
          ifVmid[v] <= regWrData[16:1];
          ifHyp[v]  <= strb.privOk ? regWrData[17] : 1'b0;
        end
      end
    end
  end

  // Lookup: lowest matching in-range allocated record wins
  always_comb begin
    lookupHit = 1'b0;
    lookupQ   = '0;
    for (int q = NQ - 1; q >= 0; q--) begin
      if (allocV[q] && allocIf[q] == lkIf && allocLidx[q] == lkLidx &&
          int'(allocIf[q]) < NIF && int'(allocLidx[q]) < LOCAL) begin
        lookupHit = 1'b1;
        lookupQ   = Q_LOG2'(q);
      end
    end
    qWrStrobe = (pgWrEn && lookupHit) ? (NQ'(1) << lookupQ) : '0;
  end
endmodule

// File: rtl/queue_alloc_ctrl.sv
module queue_alloc_ctrl
  import qalloc_pkg::*;
#(
  parameter int IF_LOG2 = 2,
  parameter int Q_LOG2  = 3,
  parameter int ADDR_W  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWrData,
  input  logic                  regPriv,
  output logic [31:0]           regRdData,
  input  logic [IF_FLD_W-1:0]   lkIf,
  input  logic [LIDX_FLD_W-1:0] lkLidx,
  input  logic                  pgWrEn,
  output logic                  lookupHit,
  output logic [Q_LOG2-1:0]     lookupQ,
  output logic [(1<<Q_LOG2)-1:0] qWrStrobe
);
  localparam int NIF = 1 << IF_LOG2;
  localparam int NQ  = 1 << Q_LOG2;

  strobe_t                         strb;
  logic                            gCfgEn, gStatEn;
  logic [NQ-1:0]                   allocV;
  logic [NQ-1:0][IF_FLD_W-1:0]     allocIf;
  logic [NQ-1:0][LIDX_FLD_W-1:0]   allocLidx;
  logic [NIF-1:0]                  ifEn, ifHyp, ifStatEn;
  logic [NIF-1:0][VMID_W-1:0]      ifVmid;

  qalloc_regdec #(.IF_LOG2(IF_LOG2), .Q_LOG2(Q_LOG2), .ADDR_W(ADDR_W)) uDec (
    .regWrEn(regWrEn), .regAddr(regAddr), .regPriv(regPriv),
    .gCfgEn(gCfgEn), .gStatEn(gStatEn),
    .allocV(allocV), .allocIf(allocIf), .allocLidx(allocLidx),
    .ifEn(ifEn), .ifVmid(ifVmid), .ifHyp(ifHyp), .ifStatEn(ifStatEn),
    .strb(strb), .regRdData(regRdData)
  );

  qalloc_state #(.IF_LOG2(IF_LOG2), .Q_LOG2(Q_LOG2)) uState (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regWrData(regWrData),
    .lkIf(lkIf), .lkLidx(lkLidx), .pgWrEn(pgWrEn),
    .gCfgEn(gCfgEn), .gStatEn(gStatEn),
    .allocV(allocV), .allocIf(allocIf), .allocLidx(allocLidx),
    .ifEn(ifEn), .ifVmid(ifVmid), .ifHyp(ifHyp), .ifStatEn(ifStatEn),
    .lookupHit(lookupHit), .lookupQ(lookupQ), .qWrStrobe(qWrStrobe)
  );
endmodule

// File: rtl/qalloc_checker.sv
module qalloc_checker
  import qalloc_pkg::*;
#(
  parameter int IF_LOG2 = 2,
  parameter int Q_LOG2  = 3,
  parameter int ADDR_W  = 16
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   regWrEn,
  input logic                                   regPriv,
  input logic [ADDR_W-1:0]                      regAddr,
  input logic [31:0]                            regRdData,
  input logic                                   pgWrEn,
  input logic                                   lookupHit,
  input logic [(1<<Q_LOG2)-1:0]                 qWrStrobe,
  input logic                                   gCfgEn,
  input logic                                   gStatEn,
  input logic [(1<<Q_LOG2)-1:0]                 allocV,
  input logic [(1<<Q_LOG2)-1:0][IF_FLD_W-1:0]   allocIf,
  input logic [(1<<Q_LOG2)-1:0][LIDX_FLD_W-1:0] allocLidx,
  input logic [(1<<IF_LOG2)-1:0]                ifEn,
  input logic [(1<<IF_LOG2)-1:0]                ifHyp,
  input logic [(1<<IF_LOG2)-1:0]                ifStatEn
);
  localparam int NIF = 1 << IF_LOG2;
  localparam logic [31:0] PARAM_WORD = {20'b0, 4'(IF_LOG2), 4'(Q_LOG2), 4'b0};

  // R2
  param_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regAddr == ADDR_W'(4)) |-> (regRdData == PARAM_WORD));

  // R3
  gstat_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gStatEn == $past(gCfgEn, 2));

  // R7
  global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(gCfgEn) && !$past(gCfgEn, 2)) |-> (ifStatEn == '0));

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(qWrStrobe));

  // R9
  strobe_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qWrStrobe != '0) |-> (pgWrEn && lookupHit));

  // R10
  alloc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(regWrEn) |-> ($stable(allocV) && $stable(allocIf) && $stable(allocLidx)));

  for (genvar v = 0; v < NIF; v++) begin : gIf
    // R6
    ifstat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ifStatEn[v] |-> $past(ifEn[v], 2));
    // R5
    hyp_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ifHyp[v]) |-> $past(regWrEn && regPriv));
  end
endmodule

bind queue_alloc_ctrl qalloc_checker #(.IF_LOG2(IF_LOG2), .Q_LOG2(Q_LOG2), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regPriv(regPriv),
  .regAddr(regAddr), .regRdData(regRdData), .pgWrEn(pgWrEn),
  .lookupHit(lookupHit), .qWrStrobe(qWrStrobe), .gCfgEn(gCfgEn),
  .gStatEn(gStatEn), .allocV(allocV), .allocIf(allocIf),
  .allocLidx(allocLidx), .ifEn(ifEn), .ifHyp(ifHyp), .ifStatEn(ifStatEn)
);

// File: tb/tb_queue_alloc_ctrl.sv
`timescale 1ns/1ps
module tb_queue_alloc_ctrl;
  localparam int IFL = 2, QL = 3;
  localparam int NIF = 1 << IFL, NQ = 1 << QL, LOC = NQ / NIF;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0, regPriv = 1'b0, pgWrEn = 1'b0;
  logic [15:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [5:0]  lkIf = '0;
  logic [6:0]  lkLidx = '0;
  logic        lookupHit;
  logic [2:0]  lookupQ;
  logic [7:0]  qWrStrobe;

  queue_alloc_ctrl #(.IF_LOG2(IFL), .Q_LOG2(QL)) dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regPriv(regPriv), .regRdData(regRdData),
    .lkIf(lkIf), .lkLidx(lkLidx), .pgWrEn(pgWrEn),
    .lookupHit(lookupHit), .lookupQ(lookupQ), .qWrStrobe(qWrStrobe)
  );

  int compared = 0, mismatched = 0;
  bit done = 0, running = 0;

  // Behavioural reference state
  int mG, mG0, mG1;
  int mAv[NQ], mAl[NQ], mAi[NQ];
  int mIe[NIF], mIv[NIF], mIh[NIF], mI0[NIF], mI1[NIF];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit isAlloc(int a);
    return a >= 'h200 && a < 'h200 + 4 * NQ && a % 4 == 0;
  endfunction
  function automatic bit isIf(int a, int off);
    return a >= 'h1000 && a < 'h1000 + 'h100 * NIF && a % 256 == off;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mG = 0; mG0 = 0; mG1 = 0;
      for (int q = 0; q < NQ; q++) begin mAv[q] = 0; mAl[q] = 0; mAi[q] = 0; end
      for (int v = 0; v < NIF; v++) begin
        mIe[v] = 0; mIv[v] = 0; mIh[v] = 0; mI0[v] = 0; mI1[v] = 0;
      end
    end else begin
      int a, d;
      mG1 = mG0; mG0 = mG;
      for (int v = 0; v < NIF; v++) begin mI1[v] = mI0[v]; mI0[v] = mIe[v] & mG; end
      if (regWrEn) begin
        a = int'(regAddr); d = int'(regWrData);
        if (a == 0) mG = d & 1;
        else if (isAlloc(a)) begin
          mAv[(a - 'h200) / 4] = d & 1;
          mAl[(a - 'h200) / 4] = (d >> 1) & 127;
          mAi[(a - 'h200) / 4] = (d >> 15) & 63;
        end else if (isIf(a, 0)) begin
          mIe[(a - 'h1000) / 256] = d & 1;
          mIv[(a - 'h1000) / 256] = (d >> 1) & 'hFFFF;
          mIh[(a - 'h1000) / 256] = regPriv ? ((d >> 17) & 1) : 0;
        end
      end
    end
  end

  function automatic int expRead(int a);
    int v, q;
    if (a == 0) return mG;
    if (a == 4) return (IFL << 8) | (QL << 4);
    if (a == 8) return mG1;
    if (isAlloc(a)) begin
      q = (a - 'h200) / 4;
      return mAv[q] | (mAl[q] << 1) | (mAi[q] << 15);
    end
    if (isIf(a, 0)) begin
      v = (a - 'h1000) / 256;
      return mIe[v] | (mIv[v] << 1) | (mIh[v] << 17);
    end
    if (isIf(a, 4)) begin
      v = (a - 'h1000) / 256;
      return mI1[v] | (((mIe[v] == 1 && mG == 0) ? 1 : 0) << 1);
    end
    return 0;
  endfunction

  function automatic string rdTag(int a);
    if (a == 0) return "R3 global config";
    if (a == 4) return "R2 param word";
    if (a == 8) return "R3 global status";
    if (isAlloc(a)) return "R4 alloc record";
    if (isIf(a, 0)) return "R5 interface config";
    if (isIf(a, 4)) return "R6 interface status";
    return "R10 unmapped read";
  endfunction

  // Reference model compared on every clock, just before the rising edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      int hq;
      bit hit;
      #4;
      hit = 0; hq = 0;
      for (int q = NQ - 1; q >= 0; q--)
        if (mAv[q] == 1 && mAi[q] == int'(lkIf) && mAl[q] == int'(lkLidx) &&
            mAi[q] < NIF && mAl[q] < LOC) begin hit = 1; hq = q; end
      check(rdTag(int'(regAddr)), regRdData, expRead(int'(regAddr)));
      check("R8 model hit", {31'b0, lookupHit}, {31'b0, hit});
      if (hit) check("R8 model queue", {29'b0, lookupQ}, hq);
      check("R9 model strobe", {24'b0, qWrStrobe}, (pgWrEn && hit) ? (1 << hq) : 0);
    end
  end

  task automatic wr(int a, int d, bit p);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 16'(a); regWrData = d; regPriv = p;
    @(posedge clk);
    #1 regWrEn = 1'b0; regPriv = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk);
    regAddr = 16'(a);
    #4 check(tag, regRdData, exp);
  endtask

  task automatic lk(int i, int l, bit expHit, int expQ, string tag);
    @(negedge clk);
    lkIf = 6'(i); lkLidx = 7'(l);
    #4 check(tag, {31'b0, lookupHit}, {31'b0, expHit});
    if (expHit) check(tag, {29'b0, lookupQ}, expQ);
  endtask

  task automatic pg(int i, int l, int expStrobe, string tag);
    @(negedge clk);
    lkIf = 6'(i); lkLidx = 7'(l); pgWrEn = 1'b1;
    #4 check(tag, {24'b0, qWrStrobe}, expStrobe);
    @(negedge clk);
    pgWrEn = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    // R1 reset state
    rd('h0, 0, "R1 reset global config");
    rd('h8, 0, "R1 reset global status");
    rd('h200, 0, "R1 reset alloc record");
    rd('h1000, 0, "R1 reset interface config");
    rd('h1004, 0, "R1 reset interface status");
    lk(0, 0, 0, 0, "R1 reset lookup miss");
    rd('h4, 'h230, "R2 param word");
    // R10 read-only and unmapped writes
    wr('h4, -1, 1); wr('h8, -1, 1); wr('h100, -1, 1);
    wr('h1008, -1, 1); wr('h1400, -1, 1); wr('h1004, -1, 1); wr('h240, -1, 1);
    rd('h4, 'h230, "R10 param unchanged");
    rd('h8, 0, "R10 status unchanged");
    rd('h1008, 0, "R10 unmapped offset");
    rd('h1000, 0, "R10 out-of-range interface no alias");
    rd('h200, 0, "R10 out-of-range queue no alias");
    // R3 global enable and two-edge status lag
    wr('h0, 1, 1);
    rd('h8, 0, "R3 status after 1 edge");
    rd('h8, 0, "R3 status after 2 edges");
    rd('h8, 1, "R3 status after 3 edges");
    rd('h0, 1, "R3 config readback");
    // R4 allocation records
    wr('h200, 'h1, 1);      // q0 -> if0 l0
    wr('h204, 'h3, 1);      // q1 -> if0 l1
    wr('h208, 'h8001, 1);   // q2 -> if1 l0
    wr('h214, 'h8003, 1);   // q5 -> if1 l1
    wr('h218, 'h8001, 1);   // q6 -> if1 l0 (duplicate)
    wr('h21C, 'h10005, 1);  // q7 -> if2 l2 (local index out of range)
    wr('h20C, -1, 1);       // q3 -> if63 l127
    wr('h210, 'h28001, 1);  // q4 -> if5 l0 (interface out of range)
    rd('h20C, 'h1F80FF, "R4 alloc fields only");
    rd('h214, 'h8003, "R4 alloc readback");
    // R8 lookup
    lk(0, 0, 1, 0, "R8 lookup if0 l0");
    lk(1, 1, 1, 5, "R8 lookup if1 l1");
    lk(1, 0, 1, 2, "R8 duplicate picks lowest");
    lk(2, 0, 0, 0, "R8 lookup miss");
    // R11 out-of-range records never match
    lk(2, 2, 0, 0, "R11 local index out of range");
    lk(63, 127, 0, 0, "R11 both fields out of range");
    lk(5, 0, 0, 0, "R11 interface out of range");
    // R9 page write steering
    pg(0, 1, 'h02, "R9 strobe q1");
    pg(2, 0, 'h00, "R9 miss drops write");
    wr('h208, 0, 1);
    lk(1, 0, 1, 6, "R8 runner-up after free");
    pg(1, 0, 'h40, "R9 strobe q6");
    // R5 interface config and privilege on hyp bit
    wr('h1000, 'h3579B, 1);
    rd('h1004, 0, "R6 if0 status after 1 edge");
    rd('h1004, 0, "R6 if0 status after 2 edges");
    rd('h1004, 1, "R6 if0 status after 3 edges");
    rd('h1000, 'h3579B, "R5 privileged config");
    wr('h1100, 'h3579B, 0);
    rd('h1100, 'h1579B, "R5 guest hyp forced zero");
    // R7 global disable
    wr('h0, 0, 1);
    rd('h1004, 3, "R7 if0 status 1 edge after disable");
    rd('h1004, 3, "R7 if0 status 2 edges after disable");
    rd('h1004, 2, "R7 if0 status 3 edges after disable");
    rd('h200, 1, "R7 alloc kept");
    wr('h1200, 1, 1);
    rd('h1204, 2, "R6 code while global off");
    wr('h0, 1, 1);
    rd('h0, 1, "R3 re-enable");
    rd('h1204, 0, "R6 code clears");
    repeat (3) @(negedge clk);
    rd('h1204, 1, "R6 if2 enabled");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule